// File: doc/BRIEF.md
# Multi-Convention Next-PC Sequencer

This block owns the fetch address of a simple in-order core and computes the next one every cycle. A two-bit mode input picks one of three RISC control-transfer conventions. In mode 0 (region style), direct jump targets keep the top four PC bits and transfers are delayed by one slot. In mode 1 (displacement style), jump targets are PC-relative and transfers take effect immediately. In mode 2 (windowed style), calls and branches carry word-scaled displacements, transfers are delayed, and an annul bit can squash the slot instruction.

The core presents the instruction fetched from `pc_o` on `instr_i`. It also supplies the branch outcome from its condition logic on `taken_i` and a computed register-indirect target on `reg_tgt_i`. The block returns the next fetch address, a squash flag for the instruction now presented, and a link write (enable, register number, value). A stall freezes all sequencing state. The block does not evaluate conditions, does not decode beyond the control fields and does not hold a register file.

Top module: `nextpc_seq`

## Requirements
- R1: While reset is asserted and after it is released, `pc_o` equals parameter RESET_VEC, `squash_o` is 0, `link_we_o` is 0 and no delayed transfer is pending.
- R2: In mode 0, opcode bits 31:26 = 0x02 (jump) or 0x03 (jump-and-link) give a target of {PC[31:28], instr[25:0], 2'b00}.
- R3: In mode 1, the same opcodes give a target of PC + 4 × instr[25:0], with the field zero-extended. Every transfer in mode 1 is non-delayed: the target appears on `pc_o` in the next accepted cycle.
- R4: In modes 0 and 1, opcode 0x04 is a conditional branch. When `taken_i` is 1 its target is PC + 4 + 4 × sign-extended instr[15:0]. Otherwise fetch continues sequentially.
- R5: In modes 0 and 2, a redirecting transfer first fetches PC + 4 (the slot) and then the target. A control-transfer instruction sitting in a slot is not decoded.
- R6: In mode 2, bits 31:30 = 01 is a call with target PC + 4 × instr[29:0]. It links to register CALL_REG (default 15).
- R7: In mode 2, bits 31:30 = 00 with bits 24:22 = 010 is a branch with target PC + 4 × sign-extended instr[21:0]. Condition bits 28:25 = 1000 always branch, 0000 never branch, and any other value follows `taken_i`.
- R8: In mode 2, a branch with bit 29 set squashes its slot when the branch is not taken, or when the condition is 1000. `squash_o` is 1 while that slot is presented, and a squashed slot produces no link write and no transfer.
- R9: Register-indirect transfers target `reg_tgt_i`. In modes 0/1 these are opcode 0 with instr[5:0] = 0x08 (no link) or 0x09 (link to instr[15:11]). In mode 2 they are bits 31:30 = 10 with bits 24:19 = 0x38 (link to instr[29:25]).
- R10: Opcode 0x03 in modes 0/1 links to RET_REG (default 31). The link value is PC + 8 in modes 0 and 2 and PC + 4 in mode 1, and `link_we_o` is 0 while `stall_i` is 1.
- R11: While `stall_i` is 1, `pc_o`, `squash_o` and any pending target hold. A pending target is applied exactly once, on the cycle the slot is accepted.
- R12: In mode 3 no instruction transfers control; `pc_o` advances by 4 on each accepted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Convention select: 0 region/delayed, 1 displacement/immediate, 2 windowed/delayed, 3 sequential |
| instr_i | input | 32 | Instruction fetched from `pc_o` |
| taken_i | input | 1 | Branch outcome from external condition logic |
| reg_tgt_i | input | 32 | Computed register-indirect target |
| stall_i | input | 1 | Hold all sequencing state |
| pc_o | output | 32 | Address of the instruction now presented |
| next_pc_o | output | 32 | Fetch address for the following cycle |
| squash_o | output | 1 | Instruction now presented is an annulled slot |
| link_we_o | output | 1 | Link register write enable |
| link_rd_o | output | 5 | Link destination register |
| link_val_o | output | 32 | Return address to write |

## Verification
The bench builds the block with RESET_VEC = 0x12345678. Every scenario then starts from an address whose top nibble and low bits make region and displacement targets differ visibly: the all-ones 26-bit field yields 0x1ffffffc in region mode and 0x22345674 in displacement mode. Negative branch offsets and stalls held across a delay slot are reached from that same starting point. Each scenario runs from a fresh reset, so expected addresses follow from the requirement formulas alone.

// File: rtl/nextpc_seq.sv
module nextpc_seq #(
  parameter logic [31:0] RESET_VEC = 32'h0000_1000,
  parameter logic [4:0]  RET_REG   = 5'd31,
  parameter logic [4:0]  CALL_REG  = 5'd15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_i,
  input  logic [31:0] instr_i,
  input  logic        taken_i,
  input  logic [31:0] reg_tgt_i,
  input  logic        stall_i,
  output logic [31:0] pc_o,
  output logic [31:0] next_pc_o,
  output logic        squash_o,
  output logic        link_we_o,
  output logic [4:0]  link_rd_o,
  output logic [31:0] link_val_o
);

  logic [31:0] pc_q, tgt_q, tgt;
  logic        pend_q, kill_q;

  wire [31:0] seq = pc_q + 32'd4;
  wire [5:0]  opc = instr_i[31:26];
  wire [5:0]  fn  = instr_i[5:0];
  wire [1:0]  op  = instr_i[31:30];
  wire [3:0]  cnd = instr_i[28:25];

  wire m_rgn = (mode_i == 2'd0);
  wire m_dsp = (mode_i == 2'd1);
  wire m_win = (mode_i == 2'd2);
  wire lg    = m_rgn | m_dsp;

  wire j_dir  = lg && (opc == 6'h02 || opc == 6'h03);
  wire j_br   = lg && (opc == 6'h04);
  wire j_reg  = lg && (opc == 6'h00) && (fn == 6'h08 || fn == 6'h09);
  wire w_call = m_win && (op == 2'b01);
  wire w_br   = m_win && (op == 2'b00) && (instr_i[24:22] == 3'b010);
  wire w_jmpl = m_win && (op == 2'b10) && (instr_i[24:19] == 6'h38);

  wire br_go = w_br ? ((cnd == 4'b1000) ? 1'b1 : (cnd == 4'b0000) ? 1'b0 : taken_i) : taken_i;
  wire w_ann = w_br && instr_i[29] && (cnd == 4'b1000 || !br_go);

  always_comb begin
    if (j_reg || w_jmpl)
      tgt = reg_tgt_i;
    else if (j_br)
      tgt = seq + {{14{instr_i[15]}}, instr_i[15:0], 2'b00};
    else if (j_dir)
      tgt = m_rgn ? {pc_q[31:28], instr_i[25:0], 2'b00}
                  : pc_q + {4'b0000, instr_i[25:0], 2'b00};
    else if (w_call)
      tgt = pc_q + {instr_i[29:0], 2'b00};
    else
      tgt = pc_q + {{8{instr_i[21]}}, instr_i[21:0], 2'b00};
  end

  wire live     = !pend_q && !kill_q;
  wire redir    = live && (j_dir || j_reg || w_call || w_jmpl || ((j_br || w_br) && br_go));
  wire dly      = !m_dsp;
  wire set_pend = redir && dly;
  wire set_kill = live && w_ann;

  wire lk_jal  = j_dir && (opc == 6'h03);
  wire lk_jalr = j_reg && (fn == 6'h09);

  assign pc_o       = pc_q;
  assign squash_o   = kill_q;
  assign next_pc_o  = pend_q ? tgt_q : (redir && !dly) ? tgt : seq;
  assign link_we_o  = live && !stall_i && (lk_jal || lk_jalr || w_call || w_jmpl);
  assign link_val_o = pc_q + (m_dsp ? 32'd4 : 32'd8);
  assign link_rd_o  = lk_jal  ? RET_REG :
                      lk_jalr ? instr_i[15:11] :
                      w_call  ? CALL_REG : instr_i[29:25];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= RESET_VEC;
      tgt_q  <= '0;
      pend_q <= 1'b0;
      kill_q <= 1'b0;
    end else if (!stall_i) begin
      pc_q   <= next_pc_o;
      pend_q <= set_pend;
      kill_q <= set_kill;
      if (set_pend) tgt_q <= tgt;
    end
  end

  // R11
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ($stable(pc_o) && $stable(squash_o)));

  // R5
  pend_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !stall_i) |=> (pc_o == $past(tgt_q)));

  // R3
  nodelay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_dsp && live && !stall_i) |=> !pend_q);

  // R8
  squash_nolink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |-> !link_we_o);

  // R12
  seq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd3 && live && !stall_i) |=> (pc_o == $past(pc_o) + 32'd4));

endmodule

// File: tb/nextpc_seq_bench.sv
`timescale 1ns/1ps
module nextpc_seq_bench;
  localparam logic [31:0] RV = 32'h1234_5678;

  logic        clk = 1'b0, rst_n = 1'b0, taken = 1'b0, stall = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [31:0] instr = '0, rtgt = '0;
  logic [31:0] pc, npc, lval;
  logic        sq, lwe;
  logic [4:0]  lrd;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  nextpc_seq #(.RESET_VEC(RV)) u_nextpc_seq (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .instr_i(instr), .taken_i(taken),
    .reg_tgt_i(rtgt), .stall_i(stall), .pc_o(pc), .next_pc_o(npc),
    .squash_o(sq), .link_we_o(lwe), .link_rd_o(lrd), .link_val_o(lval));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic restart(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; stall = 1'b0; taken = 1'b0; instr = '0; rtgt = '0; mode = m;
    tick; tick;
    rst_n = 1'b1;
    #0.1;
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 1'b0; tick;
    chk("R1 pc in reset", pc, RV);
    chk("R1 squash in reset", {31'b0, sq}, 0);
    chk("R1 link_we in reset", {31'b0, lwe}, 0);
    restart(2'd0);
    chk("R1 pc after reset", pc, RV);
  endtask

  task automatic t_region;
    restart(2'd0);
    instr = {6'h02, 26'h3ffffff}; #0.1;
    chk("R5 next is slot", npc, RV + 4);
    tick; chk("R5 slot fetched", pc, RV + 4);
    instr = '0; tick; chk("R2 region target", pc, 32'h1fff_fffc);
  endtask

  task automatic t_slot_ignored;
    restart(2'd0);
    instr = {6'h02, 26'h3ffffff}; tick;
    instr = {6'h02, 26'h0000010}; tick;
    chk("R5 slot jump ignored", pc, 32'h1fff_fffc);
    instr = '0; tick; chk("R5 sequential after target", pc, 32'h2000_0000);
  endtask

  task automatic t_disp;
    restart(2'd1);
    instr = {6'h02, 26'h3ffffff}; #0.1;
    chk("R3 next is target", npc, 32'h2234_5674);
    tick; chk("R3 no delay", pc, 32'h2234_5674);
  endtask

  task automatic t_branch;
    restart(2'd0);
    instr = {6'h04, 10'h0, 16'hfffe}; taken = 1'b1; tick;
    chk("R4 slot", pc, RV + 4);
    instr = '0; taken = 1'b0; tick;
    chk("R4 negative offset taken", pc, 32'h1234_5674);
    restart(2'd0);
    instr = {6'h04, 10'h0, 16'hfffe}; taken = 1'b0; tick; instr = '0; tick;
    chk("R4 not taken", pc, RV + 8);
    restart(2'd1);
    instr = {6'h04, 10'h0, 16'h0003}; taken = 1'b1; tick;
    chk("R4 mode1 taken direct", pc, RV + 16);
  endtask

  task automatic t_link;
    restart(2'd0);
    instr = {6'h03, 26'h1}; #0.1;
    chk("R10 link we", {31'b0, lwe}, 1);
    chk("R10 link rd 31", {27'b0, lrd}, 31);
    chk("R10 link pc+8", lval, RV + 8);
    stall = 1'b1; #0.1;
    chk("R10 no link while stalled", {31'b0, lwe}, 0);
    restart(2'd1);
    instr = {6'h03, 26'h1}; #0.1;
    chk("R10 link pc+4 mode1", lval, RV + 4);
  endtask

  task automatic t_call;
    restart(2'd2);
    instr = {2'b01, 30'h10}; #0.1;
    chk("R6 call link rd", {27'b0, lrd}, 15);
    chk("R6 call link val", lval, RV + 8);
    tick; instr = '0; tick;
    chk("R6 call target", pc, 32'h1234_56b8);
  endtask

  task automatic t_annul;
    restart(2'd2);
    instr = {2'b00, 1'b1, 4'b1000, 3'b010, 22'd4}; tick;
    chk("R8 always+annul squashes slot", {31'b0, sq}, 1);
    instr = '0; tick;
    chk("R7 always target", pc, RV + 16);
    chk("R8 squash cleared", {31'b0, sq}, 0);
    restart(2'd2);
    instr = {2'b00, 1'b1, 4'b1001, 3'b010, 22'd4}; taken = 1'b0; tick;
    chk("R8 not-taken annul squashes", {31'b0, sq}, 1);
    instr = {2'b01, 30'h10}; #0.1;
    chk("R8 squashed slot no link", {31'b0, lwe}, 0);
    tick; chk("R8 squashed call ignored", pc, RV + 8);
    restart(2'd2);
    instr = {2'b00, 1'b1, 4'b1001, 3'b010, 22'd4}; taken = 1'b1; tick;
    chk("R8 taken annul keeps slot", {31'b0, sq}, 0);
    instr = '0; tick; chk("R7 conditional taken", pc, RV + 16);
    restart(2'd2);
    instr = {2'b00, 1'b0, 4'b0000, 3'b010, 22'd4}; taken = 1'b1; tick;
    instr = '0; tick; chk("R7 never branch", pc, RV + 8);
  endtask

  task automatic t_indirect;
    restart(2'd2);
    instr = {2'b10, 5'd5, 6'h38, 19'h0}; rtgt = 32'h0000_4000; #0.1;
    chk("R9 jmpl link rd", {27'b0, lrd}, 5);
    tick; instr = '0; tick; chk("R9 jmpl target", pc, 32'h0000_4000);
    restart(2'd1);
    instr = {6'h00, 20'h0, 6'h08}; rtgt = 32'h0000_8000; tick;
    chk("R9 jr mode1", pc, 32'h0000_8000);
    restart(2'd0);
    instr = {6'h00, 5'd0, 5'd0, 5'd7, 5'd0, 6'h09}; #0.1;
    chk("R9 jalr link rd", {27'b0, lrd}, 7);
  endtask

  task automatic t_stall;
    restart(2'd0);
    instr = {6'h02, 26'h3ffffff}; stall = 1'b1; tick;
    chk("R11 stall on transfer holds", pc, RV);
    stall = 1'b0; tick; stall = 1'b1; instr = '0; tick; tick;
    chk("R11 slot held", pc, RV + 4);
    stall = 1'b0; tick; chk("R11 target after stall", pc, 32'h1fff_fffc);
    tick; chk("R11 target applied once", pc, 32'h2000_0000);
  endtask

  task automatic t_seq;
    restart(2'd3);
    instr = {6'h02, 26'h3ffffff}; tick;
    chk("R12 mode3 sequential", pc, RV + 4);
    tick; chk("R12 mode3 sequential 2", pc, RV + 8);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset; t_region; t_slot_ignored; t_disp; t_branch; t_link;
    t_call; t_annul; t_indirect; t_stall; t_seq;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule